// File: doc/BRIEF.md
# Disturbance-Observer Voltage Compensator

This block corrects the voltage command of an open-loop single-phase inverter for the sag that load current causes, and it does so without a current sensor. On every sample strobe it takes the sinusoidal voltage command and the measured output-capacitor voltage. It passes two signals through first-order low-pass filters that share one coefficient: the compensated command it produced, and the measured voltage. The difference between the two filter states is the disturbance estimate. That estimate is added to the next command.

The result is saturated to the DC-link voltage. It is presented both as a voltage and as a normalized duty value for a PWM stage. Voltages are signed 16-bit numbers at 0.05 V per LSB, so the 380 V link is 7600 LSB. Each filter state holds 16 fractional bits. The coefficient is an unsigned Q0.16 input. A value of 9503 puts the corner near 2 kHz at an 80 kHz sample rate, which lies between a tenth and a half of a 10 kHz filter resonance and above the 11th harmonic of 50 Hz. Measurements should be taken at mid-carrier so that ripple averages out.

Top module: `dob_comp`

## Requirements
- R1: While reset is asserted, both filter states are cleared, and comp_o, duty_o and valid_o are zero. The first sample after reset therefore yields comp_o equal to the saturated command.
- R2: valid_o is high exactly in the second clock cycle after a cycle in which sample_i is high, for one cycle when strobes are at least three cycles apart.
- R3: cmd_i, meas_i and coef_i are taken only in the strobe cycle. comp_o = sat(cmd + est), where est = floor((Sc − Sm + 2^15) / 2^16) and Sc, Sm are the two filter states (Q16.16) as they stood before this sample.
- R4: On each sample, every state S with input x is updated to S + floor(((x·2^16 − S)·a + 2^15) / 2^16), where a is the coefficient. The command filter takes comp_o as x; the measurement filter takes meas_i.
- R5: comp_o is limited to the range −7600 to +7600.
- R6: The command filter integrates the saturated comp_o, not the unsaturated sum, so the estimate does not wind up while the output is clipped.
- R7: duty_o (Q1.15) = floor((comp_o·282563 + 2^15) / 2^16), limited to ±32767. Here 282563 = floor(2^31/7600).
- R8: comp_o and duty_o change only in the cycle in which valid_o is high, and hold between samples.
- R9: When the measured voltage equals the previous comp_o minus a constant droop, the measured voltage settles to within 1 LSB of a constant command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe |
| cmd_i | input | 16 | Voltage command, signed, 0.05 V/LSB |
| meas_i | input | 16 | Measured capacitor voltage, signed, 0.05 V/LSB |
| coef_i | input | 16 | Filter coefficient, unsigned Q0.16 |
| comp_o | output | 16 | Compensated command, signed, saturated to ±7600 |
| duty_o | output | 16 | Normalized duty, signed Q1.15 |
| valid_o | output | 1 | Outputs updated this cycle |

## Verification
Saturation of the compensated command and the filter update fall on the same clock edge, so the value that is clipped is also the value that is integrated. The bench provokes this by holding a large command against a heavy droop: the estimate then drives the sum past the 7600 limit for hundreds of samples. The droop is then removed. Each output is judged against a bit-exact model that integrates the clipped value. A design that integrated the raw sum would wind up, and would show an error after the release.

// File: rtl/dob_comp.sv
module dob_comp #(
  parameter int W         = 16,
  parameter int FRAC      = 16,
  parameter int VDC_LSB   = 7600,
  parameter int DUTY_FRAC = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_i,
  input  logic signed [W-1:0] cmd_i,
  input  logic signed [W-1:0] meas_i,
  input  logic [FRAC-1:0]     coef_i,
  output logic signed [W-1:0] comp_o,
  output logic signed [W-1:0] duty_o,
  output logic                valid_o
);
  localparam int SW = W + FRAC;
  localparam int EW = SW + 1;
  localparam int PW = EW + FRAC + 1;
  localparam int CW = W + 2;
  localparam logic signed [EW-1:0] RND_E = EW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] RND_P = PW'(1) <<< (FRAC - 1);
  localparam logic signed [63:0]   RND_D = 64'sd1 <<< (FRAC - 1);
  localparam logic signed [63:0]   RECIP = (64'sd1 <<< (DUTY_FRAC + FRAC)) / VDC_LSB;
  localparam logic signed [63:0]   DHI   = (64'sd1 <<< DUTY_FRAC) - 64'sd1;
  localparam logic signed [CW-1:0] VHI   = CW'(VDC_LSB);
  localparam logic signed [CW-1:0] VLO   = -CW'(VDC_LSB);

  logic                 s1;
  logic signed [W-1:0]  cmd_q, meas_q;
  logic [FRAC-1:0]      coef_q;
  logic signed [SW-1:0] yc, ym;

  function automatic logic signed [SW-1:0] lp_step(
    input logic signed [W-1:0]  x,
    input logic signed [SW-1:0] y,
    input logic [FRAC-1:0]      a
  );
    logic signed [SW-1:0] xw;
    logic signed [EW-1:0] d;
    logic signed [PW-1:0] p;
    xw = {x, {FRAC{1'b0}}};
    d  = EW'(xw) - EW'(y);
    p  = (PW'(d) * PW'($signed({1'b0, a})) + RND_P) >>> FRAC;
    return y + SW'(p);
  endfunction

  logic signed [EW-1:0] est_full, est_sh;
  logic signed [CW-1:0] sum;
  logic signed [W-1:0]  comp_sat, duty_sat;
  logic signed [63:0]   dsh;

  assign est_full = EW'(yc) - EW'(ym) + RND_E;
  assign est_sh   = est_full >>> FRAC;
  assign sum      = CW'(cmd_q) + CW'(est_sh);
  assign comp_sat = (sum > VHI) ? W'(VHI) : (sum < VLO) ? W'(VLO) : W'(sum);
  assign dsh      = (64'(comp_sat) * RECIP + RND_D) >>> FRAC;
  assign duty_sat = (dsh > DHI) ? W'(DHI) : (dsh < -DHI) ? W'(-DHI) : W'(dsh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b0;
      valid_o <= 1'b0;
      cmd_q   <= '0;
      meas_q  <= '0;
      coef_q  <= '0;
      yc      <= '0;
      ym      <= '0;
      comp_o  <= '0;
      duty_o  <= '0;
    end else begin
      s1      <= sample_i;
      valid_o <= s1;
      if (sample_i) begin
        cmd_q  <= cmd_i;
        meas_q <= meas_i;
        coef_q <= coef_i;
      end
      if (s1) begin
        comp_o <= comp_sat;
        duty_o <= duty_sat;
        yc     <= lp_step(comp_sat, yc, coef_q);
        ym     <= lp_step(meas_q, ym, coef_q);
      end
    end
  end
endmodule

// File: rtl/dob_comp_chk.sv
module dob_comp_chk #(
  parameter int W       = 16,
  parameter int VDC_LSB = 7600
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_i,
  input logic signed [W-1:0] comp_o,
  input logic signed [W-1:0] duty_o,
  input logic                valid_o
);
  assert_valid_after_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |-> ##2 valid_o);
  assert_valid_has_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(sample_i, 2));
  assert_comp_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_o <= W'(VDC_LSB)) && (comp_o >= -W'(VDC_LSB)));
  assert_duty_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((comp_o > 0) == (duty_o > 0)) && ((comp_o < 0) == (duty_o < 0)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(comp_o) && $stable(duty_o)));
endmodule

bind dob_comp dob_comp_chk #(.W(W), .VDC_LSB(VDC_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
  .comp_o(comp_o), .duty_o(duty_o), .valid_o(valid_o)
);

// File: tb/dob_comp_bench.sv
module dob_comp_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_2K = 16'd9503;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b0;
  logic signed [15:0] cmd_i = '0, meas_i = '0;
  logic [15:0] coef_i = '0;
  logic signed [15:0] comp_o, duty_o;
  logic valid_o;

  int checks = 0, errors = 0;
  longint myc = 0, mym = 0;
  logic signed [15:0] last_comp, last_duty;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dob_comp u_dob_comp (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cmd_i(cmd_i),
    .meas_i(meas_i), .coef_i(coef_i), .comp_o(comp_o), .duty_o(duty_o),
    .valid_o(valid_o)
  );

  typedef struct packed {
    logic signed [15:0] cmd;
    logic signed [15:0] meas;
    logic signed [15:0] comp;
    logic signed [15:0] duty;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{16'sd1000,  16'sd300,    16'sd1000,  16'sd4312},
    '{-16'sd1000, -16'sd5000,  -16'sd1000, -16'sd4312},
    '{16'sd0,     16'sd7000,   16'sd0,     16'sd0},
    '{16'sd1,     -16'sd1,     16'sd1,     16'sd4},
    '{-16'sd1,    16'sd1,      -16'sd1,    -16'sd4},
    '{16'sd3800,  16'sd0,      16'sd3800,  16'sd16384},
    '{16'sd9000,  16'sd9000,   16'sd7600,  16'sd32767},
    '{-16'sd9000, -16'sd30000, -16'sd7600, -16'sd32767}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input longint cmd, input longint meas, input longint a,
                       output longint comp, output longint duty);
    longint sum, dd;
    sum  = cmd + ((myc - mym + 32768) >>> 16);
    comp = (sum > 7600) ? 7600 : (sum < -7600) ? -7600 : sum;
    dd   = (comp * 282563 + 32768) >>> 16;
    duty = (dd > 32767) ? 32767 : (dd < -32767) ? -32767 : dd;
    myc  = myc + ((((comp <<< 16) - myc) * a + 32768) >>> 16);
    mym  = mym + ((((meas <<< 16) - mym) * a + 32768) >>> 16);
  endtask

  task automatic do_sample(input logic signed [15:0] c, input logic signed [15:0] m,
                           input logic [15:0] a);
    logic signed [15:0] pc, pd;
    @(negedge clk);
    sample_i = 1'b1; cmd_i = c; meas_i = m; coef_i = a;
    pc = comp_o; pd = duty_o;
    @(negedge clk);
    sample_i = 1'b0; cmd_i = 16'sh7fff; meas_i = -16'sh7fff; coef_i = 16'hffff;
    if (valid_o !== 1'b0 || comp_o !== pc || duty_o !== pd) check("R8 early change", 1, 0);
    @(negedge clk);
    if (valid_o !== 1'b1) check("R2 valid at +2", valid_o, 1);
    last_comp = comp_o; last_duty = duty_o;
    @(negedge clk);
    if (valid_o !== 1'b0) check("R2 valid pulse", valid_o, 0);
    if (comp_o !== last_comp) check("R8 hold", comp_o, last_comp);
  endtask

  task automatic run_model(input longint c, input longint m, input longint a, input string req);
    longint ec, ed;
    model(c, m, a, ec, ed);
    do_sample(16'(c), 16'(m), 16'(a));
    check(req, comp_o, ec);
    check("R7 duty", duty_o, ed);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint droop, meas;
    repeat (3) @(negedge clk);
    check("R1 reset comp", comp_o, 0);
    check("R1 reset duty", duty_o, 0);
    check("R1 reset valid", valid_o, 0);
    rst_n = 1'b1;

    // coefficient zero keeps both states at zero: comp is the saturated command (R3, R5, R7)
    foreach (TBL[i]) begin
      do_sample(TBL[i].cmd, TBL[i].meas, 16'd0);
      check("R5 R3 table comp", comp_o, TBL[i].comp);
      check("R7 table duty", duty_o, TBL[i].duty);
    end

    // step load: plant meas = previous comp minus droop (R3, R4, R9)
    meas = 0;
    for (int n = 0; n < 600; n++) begin
      droop = (n < 100) ? 0 : 300;
      run_model(3000, meas, A_2K, "R4 step");
      meas = comp_o - droop;
    end
    check("R9 settled", (meas >= 2999 && meas <= 3001) ? 1 : 0, 1);

    // reset mid-run clears states (R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset comp", comp_o, 0);
    check("R1 mid reset valid", valid_o, 0);
    rst_n = 1'b1; myc = 0; mym = 0;
    do_sample(16'sd1234, 16'sd0, A_2K);
    check("R1 first after reset", comp_o, 1234);
    myc = ((((64'sd1234 <<< 16)) * 9503 + 32768) >>> 16);
    mym = 0;

    // sine command with a nonlinear-ish droop (R3, R4)
    meas = 0;
    for (int n = 0; n < 1600; n++) begin
      longint c;
      c = longint'($rtoi(5657.0 * $sin(6.283185307179586 * n / 1600.0)));
      droop = (c > 4000 || c < -4000) ? c / 8 : 0;
      run_model(c, meas, A_2K, "R3 sine");
      meas = comp_o - droop;
    end

    // clipped output under heavy droop, then release (R6, R5)
    for (int n = 0; n < 500; n++) begin
      droop = (n < 300) ? 1500 : 0;
      run_model(7400, meas, A_2K, "R6 windup");
      meas = comp_o - droop;
    end
    check("R6 settled after release", (meas >= 7399 && meas <= 7401) ? 1 : 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule